// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in memory, for a fixed 1 KB page. The virtual address has three parts. The top 12 bits index the root table. The next 10 bits index a leaf table. The low 10 bits pass through unchanged as the byte offset within the page.

A translation request comes from the CPU or from the miss path of a translation cache, together with the root table base that is current for that request. The walker makes two dependent 4-byte reads through a memory read port that may stall for any number of cycles. It checks the valid bit of each entry it reads. It then returns either a physical address or a fault that names the level where the walk stopped. Each entry keeps its valid flag in bit 0 and a 1 KB-aligned physical base in bits 31:10. In a root entry that base locates a leaf table; in a leaf entry it is the page frame.

Top module: `ptw_top`

## Requirements
- R1: The first read after a request is accepted goes to root base + 4 × VA[31:20], using the base and virtual address captured at acceptance.
- R2: After a valid root entry E, the second read goes to {E[31:10], 10'b0} + 4 × VA[19:10].
- R3: After a valid leaf entry L, the response has rsp_fault = 0, rsp_level = 0 and rsp_paddr = {L[31:10], VA[9:0]}.
- R4: A root entry with bit 0 clear ends the walk after exactly one read. The response then has rsp_fault = 1, rsp_level = 0 and rsp_paddr = 0.
- R5: A leaf entry with bit 0 clear ends the walk after exactly two reads. The response then has rsp_fault = 1, rsp_level = 1 and rsp_paddr = 0.
- R6: mem_rd stays high with a stable mem_addr until mem_rsp_valid arrives, whatever the latency. A mem_rsp_valid pulse while no read is pending has no effect.
- R7: rsp_valid, rsp_paddr, rsp_fault and rsp_level stay constant until rsp_ready is seen high.
- R8: req_ready is high only when the walker is idle. It drops the cycle after acceptance and returns only in the cycle after the response is taken. A request presented in the same cycle as the response hand-off is not accepted.
- R9: Changes to req_vaddr or root_base after acceptance do not affect the walk in progress.
- R10: While rst is high, and in the first cycle after it, req_ready = 1, mem_rd = 0 and rsp_valid = 0. This also holds when reset interrupts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base of the root table |
| mem_rd | output | 1 | Table read pending |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned table entry |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Walk stopped on an invalid entry |
| rsp_level | output | 1 | Faulting level: 0 root, 1 leaf |

## Verification
The response hand-off and the acceptance of the next request can fall in the same cycle. The bench provokes this on every walk: in the cycle where it raises rsp_ready, it also raises req_valid with a fresh address. It then requires req_ready to be low in that cycle, and one cycle later it requires req_ready high and rsp_valid low. A second overlap is a stray memory-valid pulse that arrives while no read is pending. The bench injects one while the walker is idle and requires the handshake outputs to stay unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int PTE_W   = 32;
    localparam int OFF_W   = 10;
    localparam int LEAF_W  = 10;
    localparam int ROOT_W  = VA_W - OFF_W - LEAF_W;
    localparam int PPN_W   = PTE_W - OFF_W;
    localparam int ESZ_LG  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT,
        ST_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic {
        LVL_ROOT = 1'b0,
        LVL_LEAF = 1'b1
    } walk_level_e;

    typedef struct packed {
        logic [ROOT_W-1:0] root_idx;
        logic [LEAF_W-1:0] leaf_idx;
        logic [OFF_W-1:0]  off;
    } va_fields_t;

    function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] tbl,
                                                  input logic [ROOT_W-1:0] idx);
        logic [PA_W-1:0] scaled;
        scaled = PA_W'(idx) << ESZ_LG;
        return tbl + scaled;
    endfunction

    function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
        return pte[0];
    endfunction

    function automatic logic [PA_W-1:0] pte_base(input logic [PTE_W-1:0] pte);
        return {pte[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
(
    input  va_fields_t        va,
    input  logic [PA_W-1:0]   root_tbl,
    input  logic [PA_W-1:0]   leaf_tbl,
    output logic [PA_W-1:0]   root_slot,
    output logic [PA_W-1:0]   leaf_slot
);
    always_comb begin
        root_slot = slot_addr(root_tbl, va.root_idx);
        leaf_slot = slot_addr(leaf_tbl, ROOT_W'(va.leaf_idx));
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   root_base,
    output logic              mem_rd,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_level,
    output va_fields_t        va_q,
    output logic [PA_W-1:0]   root_q,
    output logic [PA_W-1:0]   leaf_q,
    input  logic [PA_W-1:0]   root_slot,
    input  logic [PA_W-1:0]   leaf_slot
);
    walk_state_e state_q, state_d;
    walk_level_e lvl_q;
    logic [PA_W-1:0] paddr_q;
    logic accept, rd_done, ent_ok;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign rd_done = mem_rd && mem_rsp_valid;
    assign ent_ok  = pte_ok(mem_rsp_data);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ROOT;
            ST_ROOT:  if (mem_rsp_valid) state_d = ent_ok ? ST_LEAF : ST_FAULT;
            ST_LEAF:  if (mem_rsp_valid) state_d = ent_ok ? ST_DONE : ST_FAULT;
            ST_DONE,
            ST_FAULT: if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            root_q  <= '0;
            leaf_q  <= '0;
            paddr_q <= '0;
            lvl_q   <= LVL_ROOT;
        end else begin
            state_q <= state_d;
            if (accept) begin
                va_q    <= va_fields_t'(req_vaddr);
                root_q  <= root_base;
                paddr_q <= '0;
                lvl_q   <= LVL_ROOT;
            end
            if (rd_done && state_q == ST_ROOT && ent_ok)
                leaf_q <= pte_base(mem_rsp_data);
            if (rd_done && state_q == ST_LEAF) begin
                if (ent_ok)
                    paddr_q <= pte_base(mem_rsp_data) | PA_W'(va_q.off);
                else
                    lvl_q <= LVL_LEAF;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_rd    = (state_q == ST_ROOT) || (state_q == ST_LEAF);
    assign mem_addr  = (state_q == ST_LEAF) ? leaf_slot : root_slot;
    assign rsp_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign rsp_fault = (state_q == ST_FAULT);
    assign rsp_paddr = paddr_q;
    assign rsp_level = lvl_q;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   root_base,
    output logic              mem_rd,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_level
);
    va_fields_t      va_q;
    logic [PA_W-1:0] root_q, leaf_q, root_slot, leaf_slot;

    ptw_index u_index (
        .va        (va_q),
        .root_tbl  (root_q),
        .leaf_tbl  (leaf_q),
        .root_slot (root_slot),
        .leaf_slot (leaf_slot)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .root_base     (root_base),
        .mem_rd        (mem_rd),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_level     (rsp_level),
        .va_q          (va_q),
        .root_q        (root_q),
        .leaf_q        (leaf_q),
        .root_slot     (root_slot),
        .leaf_slot     (leaf_slot)
    );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             mem_rd,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             rsp_level
);
    logic [VA_W-1:0] seen_va;

    always_ff @(posedge clk) begin
        if (rst) seen_va <= '0;
        else if (req_valid && req_ready) seen_va <= req_vaddr;
    end

    a_r6_read_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rsp_valid) |=> (mem_rd && $stable(mem_addr)));

    a_r7_resp_held: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_level)));

    a_r8_busy_while_resp: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_rd) |-> !req_ready);

    a_r8_ready_after_take: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

    a_r8_drop_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && mem_rd));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == seen_va[OFF_W-1:0]
                                       && !rsp_level));

    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r10_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !mem_rd && !rsp_valid));
endmodule

bind ptw_top ptw_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_rd        (mem_rd),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] base;
        logic [3:0]  lat;
        logic [1:0]  bad;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 32'h0004_0000, 4'd0, 2'd0},
        '{32'hFFFF_FFFF, 32'h0010_0000, 4'd3, 2'd0},
        '{32'h0000_0000, 32'h0002_0000, 4'd1, 2'd0},
        '{32'hABCD_E3FF, 32'h0008_0000, 4'd2, 2'd1},
        '{32'h0040_0C01, 32'h000C_0000, 4'd4, 2'd2},
        '{32'h8001_0400, 32'hFFFF_F000, 4'd1, 2'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, rsp_ready = 1'b0, stray = 1'b0;
    logic [31:0] req_vaddr = '0, root_base = '0;
    logic req_ready, mem_rd, rsp_valid, rsp_fault, rsp_level;
    logic [31:0] mem_addr, rsp_paddr;
    logic mem_vld = 1'b0;
    logic [31:0] mem_data = '0;
    logic [31:0] bad_addr = 32'hFFFF_FFFF;
    int lat = 0, cnt = 0, rd_cnt = 0;
    logic [31:0] rd_log [256];
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_vld | stray), .mem_rsp_data(mem_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    function automatic logic [31:0] entry_of(input logic [31:0] a, input logic [31:0] bad);
        logic [31:0] h;
        h = (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        return {h[31:10], 9'b0, (a != bad)};
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            mem_vld <= 1'b0;
            cnt     <= 0;
        end else if (mem_vld) begin
            mem_vld <= 1'b0;
        end else if (mem_rd) begin
            if (cnt >= lat) begin
                mem_vld  <= 1'b1;
                mem_data <= entry_of(mem_addr, bad_addr);
                rd_log[rd_cnt[7:0]] <= mem_addr;
                rd_cnt   <= rd_cnt + 1;
                cnt      <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic walk(input vec_t v);
        logic [31:0] o_addr, o_ent, l_addr, l_ent, pa;
        logic [31:0] h_pa;
        logic h_f, h_l;
        int start, n;
        o_addr = v.base + {18'b0, v.va[31:20], 2'b00};
        o_ent  = entry_of(o_addr, 32'hFFFF_FFFF);
        l_addr = {o_ent[31:10], 10'b0} + {20'b0, v.va[19:10], 2'b00};
        bad_addr = (v.bad == 2'd1) ? o_addr : (v.bad == 2'd2) ? l_addr : 32'hFFFF_FFFF;
        l_ent  = entry_of(l_addr, bad_addr);
        pa     = {l_ent[31:10], v.va[9:0]};
        lat    = int'(v.lat);
        @(negedge clk);
        start = rd_cnt;
        chk("R8", "ready when idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = v.va; root_base = v.base;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~v.va; root_base = ~v.base;
        chk("R8", "ready low after accept", {31'b0, req_ready}, 32'd0);
        n = 0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
        chk("R1", "root read address", rd_log[start[7:0]], o_addr);
        if (v.bad == 2'd1) begin
            chk("R4", "read count", rd_cnt - start, 32'd1);
            chk("R4", "fault", {31'b0, rsp_fault}, 32'd1);
            chk("R4", "level", {31'b0, rsp_level}, 32'd0);
            chk("R4", "paddr", rsp_paddr, 32'd0);
        end else begin
            chk("R2", "leaf read address", rd_log[(start + 1) % 256], l_addr);
            chk("R9", "read count", rd_cnt - start, 32'd2);
            if (v.bad == 2'd2) begin
                chk("R5", "fault", {31'b0, rsp_fault}, 32'd1);
                chk("R5", "level", {31'b0, rsp_level}, 32'd1);
                chk("R5", "paddr", rsp_paddr, 32'd0);
            end else begin
                chk("R3", "fault", {31'b0, rsp_fault}, 32'd0);
                chk("R3", "level", {31'b0, rsp_level}, 32'd0);
                chk("R3", "paddr", rsp_paddr, pa);
            end
        end
        h_pa = rsp_paddr; h_f = rsp_fault; h_l = rsp_level;
        repeat (2) @(negedge clk);
        chk("R7", "held valid", {31'b0, rsp_valid}, 32'd1);
        chk("R7", "held result", {rsp_paddr[29:0], rsp_fault, rsp_level},
            {h_pa[29:0], h_f, h_l});
        rsp_ready = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0BAD_0BAD;
        chk("R8", "no accept during hand-off", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0; rsp_ready = 1'b0;
        chk("R8", "ready after take", {31'b0, req_ready}, 32'd1);
        chk("R8", "response cleared", {31'b0, rsp_valid}, 32'd0);
        chk("R8", "no extra read", {31'b0, mem_rd}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R10", "no read in reset", {31'b0, mem_rd}, 32'd0);
        chk("R10", "no response in reset", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) walk(VECS[i]);

        // R6: stray memory valid while idle
        @(negedge clk);
        stray = 1'b1; mem_data = 32'hFFFF_FFFF;
        @(negedge clk);
        stray = 1'b0;
        chk("R6", "idle after stray", {31'b0, req_ready}, 32'd1);
        chk("R6", "no response after stray", {31'b0, rsp_valid}, 32'd0);
        chk("R6", "no read after stray", {31'b0, mem_rd}, 32'd0);
        walk(VECS[0]);

        // R10: reset during a walk
        lat = 6;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h5555_AAAA; root_base = 32'h0001_0000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6", "read pending", {31'b0, mem_rd}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "ready after abort", {31'b0, req_ready}, 32'd1);
        chk("R10", "read dropped", {31'b0, mem_rd}, 32'd0);
        chk("R10", "no response after abort", {31'b0, rsp_valid}, 32'd0);
        walk(VECS[2]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule